// File: doc/BRIEF.md
# Control-Coded Bidirectional Shift Register

This block is a small parallel-out shift register whose action on each rising clock edge is selected by a two-bit control code. Depending on the code it moves its contents one place toward the most significant end, one place toward the least significant end, or leaves them alone. Whenever it shifts, the position left empty is filled from a dedicated serial input for that direction. The contents are always visible on the parallel output.

One of the four control codes has no assigned action. Rather than leave that case open, the block keeps its contents unchanged when it sees that code and raises a one-cycle flag so surrounding logic can see that a reserved code was applied. A synchronous reset clears the register and the flag and takes priority over any control code. The width is a parameter with a default of four bits. The bit positions of the shift directions and the numeric values of the control codes are fixed, because both set the block's behaviour.

Top module: `dir_shreg`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `q` becomes all zeros and `bad_code` becomes 0 after that edge, whatever `ctl`, `sin_lo` and `sin_hi` hold.
- R2: With `ctl` = 3 (binary 11) at a rising edge, `q` shifts toward the MSB. The old MSB is lost and bit 0 takes the value of `sin_lo`, so a 4-bit `q` becomes {q[2:0], sin_lo}.
- R3: With `ctl` = 2 (binary 10) at a rising edge, `q` shifts toward the LSB. The old bit 0 is lost and the MSB takes the value of `sin_hi`, so a 4-bit `q` becomes {sin_hi, q[3:1]}.
- R4: With `ctl` = 1 (binary 01) at a rising edge, `q` keeps its value, and `sin_lo` and `sin_hi` have no effect on it.
- R5: With the reserved code `ctl` = 0 (binary 00) at a rising edge, `q` keeps its value, and both serial inputs have no effect on it.
- R6: `bad_code` is 1 for exactly the clock cycle after an edge that sampled `ctl` = 0 with `rst` low. After any other edge it is 0.
- R7: `q` changes only at a rising clock edge. Changes on `ctl`, `sin_lo` or `sin_hi` between edges leave `q` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl | input | 2 | Action code: 3 shift toward MSB, 2 shift toward LSB, 1 hold, 0 reserved |
| sin_lo | input | 1 | Serial bit entering bit 0 on a shift toward the MSB |
| sin_hi | input | 1 | Serial bit entering the MSB on a shift toward the LSB |
| q | output | WIDTH (4) | Parallel register contents |
| bad_code | output | 1 | One-cycle indication that the reserved code was sampled |

## Verification
The bench shifts full patterns through the register in both directions. A design that swapped the serial inputs, or mixed up which end is filled in which direction, would produce mirrored or corrupted words. It toggles both serial inputs while the hold and reserved codes are applied. A design that treated code 0 as a shift or a load, or that let a serial bit leak in during hold, would show a changed `q`. It also checks that the flag lasts exactly one cycle per reserved code, that reset wins over an active shift code, and that input changes between edges never reach the output early.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

   // Control codes as seen on the ctl port; values are part of the interface.
   typedef enum logic [1:0] {
      CODE_RSVD  = 2'd0,
      CODE_HOLD  = 2'd1,
      CODE_DOWN  = 2'd2,
      CODE_UP    = 2'd3
   } shreg_code_e;

   // Decoded per-bit action.
   typedef enum logic [1:0] {
      ACT_KEEP = 2'd0,
      ACT_UP   = 2'd1,
      ACT_DOWN = 2'd2
   } shreg_act_e;

endpackage

// File: rtl/shreg_decode.sv
module shreg_decode
   import shreg_pkg::*;
(
   input  logic [1:0] ctl,
   output shreg_act_e act,
   output logic       rsvd
);

   always_comb begin
      act  = ACT_KEEP;
      rsvd = 1'b0;
      case (shreg_code_e'(ctl))
         CODE_UP:   act = ACT_UP;
         CODE_DOWN: act = ACT_DOWN;
         CODE_HOLD: act = ACT_KEEP;
         default: begin
            act  = ACT_KEEP;
            rsvd = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/shreg_cell.sv
module shreg_cell
   import shreg_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  shreg_act_e act,
   input  logic       from_lower,
   input  logic       from_upper,
   output logic       bit_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_q <= 1'b0;
      end else begin
         case (act)
            ACT_UP:   bit_q <= from_lower;
            ACT_DOWN: bit_q <= from_upper;
            default:  bit_q <= bit_q;
         endcase
      end
   end

endmodule

// File: rtl/shreg_flag.sv
module shreg_flag (
   input  logic clk,
   input  logic rst,
   input  logic rsvd,
   output logic flag
);

   always_ff @(posedge clk) begin
      if (rst) flag <= 1'b0;
      else     flag <= rsvd;
   end

endmodule

// File: rtl/dir_shreg.sv
module dir_shreg
   import shreg_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       ctl,
   input  logic             sin_lo,
   input  logic             sin_hi,
   output logic [WIDTH-1:0] q,
   output logic             bad_code
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_check
         $error("dir_shreg: WIDTH must be at least 2");
      end
   endgenerate

   shreg_act_e act;
   logic       rsvd;

   shreg_decode u_dec (
      .ctl  (ctl),
      .act  (act),
      .rsvd (rsvd)
   );

   shreg_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .rsvd (rsvd),
      .flag (bad_code)
   );

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_bit
         logic lower_src;
         logic upper_src;
         if (i == 0) begin : g_lo_end
            assign lower_src = sin_lo;
         end else begin : g_lo_mid
            assign lower_src = q[i-1];
         end
         if (i == MSB) begin : g_hi_end
            assign upper_src = sin_hi;
         end else begin : g_hi_mid
            assign upper_src = q[i+1];
         end
         shreg_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .act        (act),
            .from_lower (lower_src),
            .from_upper (upper_src),
            .bit_q      (q[i])
         );
      end
   endgenerate

endmodule

// File: rtl/dir_shreg_chk.sv
module dir_shreg_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       ctl,
   input logic             sin_lo,
   input logic             sin_hi,
   input logic [WIDTH-1:0] q,
   input logic             bad_code
);

   // R1
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (q == '0 && !bad_code));

   // R2
   p_shift_up_r2: assert property (@(posedge clk) disable iff (rst)
      (ctl == 2'd3) |=> (q == {$past(q[WIDTH-2:0]), $past(sin_lo)}));

   // R3
   p_shift_down_r3: assert property (@(posedge clk) disable iff (rst)
      (ctl == 2'd2) |=> (q == {$past(sin_hi), $past(q[WIDTH-1:1])}));

   // R4
   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (ctl == 2'd1) |=> $stable(q));

   // R5
   p_rsvd_keep_r5: assert property (@(posedge clk) disable iff (rst)
      (ctl == 2'd0) |=> $stable(q));

   // R6
   p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
      (ctl == 2'd0) |=> bad_code);

   p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (ctl != 2'd0) |=> !bad_code);

endmodule

bind dir_shreg dir_shreg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ctl      (ctl),
   .sin_lo   (sin_lo),
   .sin_hi   (sin_hi),
   .q        (q),
   .bad_code (bad_code)
);

// File: tb/dir_shreg_test.sv
module dir_shreg_test;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst;
   logic [1:0]   ctl;
   logic         sin_lo;
   logic         sin_hi;
   logic [W-1:0] q;
   logic         bad_code;

   int vectors = 0;
   int errors  = 0;

   logic [W-1:0] exp_q;
   logic         exp_flag;

   dir_shreg #(.WIDTH(W)) uut (
      .clk      (clk),
      .rst      (rst),
      .ctl      (ctl),
      .sin_lo   (sin_lo),
      .sin_hi   (sin_hi),
      .q        (q),
      .bad_code (bad_code)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input logic [W-1:0] act_v,
                        input logic [W-1:0] exp_v);
      vectors++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, act_v, exp_v);
      end
   endtask

   // Apply one edge with given inputs, update the model, check both outputs.
   task automatic step(input string req, input logic [1:0] c,
                       input logic sl, input logic sh, input logic r);
      @(negedge clk);
      ctl = c; sin_lo = sl; sin_hi = sh; rst = r;
      if (r) begin
         exp_q = '0; exp_flag = 1'b0;
      end else begin
         case (c)
            2'd3: exp_q = {exp_q[W-2:0], sl};
            2'd2: exp_q = {sh, exp_q[W-1:1]};
            default: exp_q = exp_q;
         endcase
         exp_flag = (c == 2'd0);
      end
      @(posedge clk);
      #1;
      check(req, q, exp_q);
      check({req, " flag"}, {{(W-1){1'b0}}, bad_code}, {{(W-1){1'b0}}, exp_flag});
   endtask

   task automatic t_reset;           // R1
      step("R1", 2'd3, 1'b1, 1'b1, 1'b1);
      step("R1", 2'd3, 1'b1, 1'b1, 1'b1);
   endtask

   task automatic t_shift_up;        // R2
      step("R2", 2'd3, 1'b1, 1'b0, 1'b0);
      step("R2", 2'd3, 1'b0, 1'b1, 1'b0);
      step("R2", 2'd3, 1'b1, 1'b1, 1'b0);
      step("R2", 2'd3, 1'b1, 1'b0, 1'b0);
      step("R2", 2'd3, 1'b0, 1'b0, 1'b0);   // MSB falls off
   endtask

   task automatic t_shift_down;      // R3
      step("R3", 2'd2, 1'b0, 1'b1, 1'b0);
      step("R3", 2'd2, 1'b1, 1'b0, 1'b0);
      step("R3", 2'd2, 1'b1, 1'b0, 1'b0);
      step("R3", 2'd2, 1'b0, 1'b1, 1'b0);
      step("R3", 2'd2, 1'b0, 1'b0, 1'b0);   // bit 0 falls off
   endtask

   task automatic t_hold;            // R4
      step("R4", 2'd1, 1'b1, 1'b1, 1'b0);
      step("R4", 2'd1, 1'b0, 1'b0, 1'b0);
      step("R4", 2'd1, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_reserved;        // R5 and R6
      step("R5", 2'd0, 1'b1, 1'b1, 1'b0);
      step("R6", 2'd0, 1'b0, 1'b1, 1'b0);
      step("R6", 2'd1, 1'b1, 1'b1, 1'b0);   // flag must drop
      step("R5", 2'd0, 1'b1, 1'b0, 1'b0);
      step("R6", 2'd3, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_between_edges;   // R7
      @(negedge clk);
      ctl = 2'd3; sin_lo = ~exp_q[0]; sin_hi = ~exp_q[W-1];
      #2;
      check("R7", q, exp_q);
      ctl = 2'd2;
      #1;
      check("R7", q, exp_q);
      ctl = 2'd1;
      @(posedge clk);
      #1;
      check("R7", q, exp_q);
   endtask

   task automatic t_reset_override;  // R1
      step("R2", 2'd3, 1'b1, 1'b1, 1'b0);
      step("R1", 2'd3, 1'b1, 1'b1, 1'b1);
      step("R1", 2'd0, 1'b1, 1'b1, 1'b1);   // no flag under reset
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      rst = 1'b1; ctl = 2'd1; sin_lo = 1'b0; sin_hi = 1'b0;
      exp_q = '0; exp_flag = 1'b0;
      t_reset();
      t_shift_up();
      t_shift_down();
      step("R2", 2'd3, 1'b1, 1'b0, 1'b0);
      step("R2", 2'd3, 1'b0, 1'b0, 1'b0);
      step("R2", 2'd3, 1'b1, 1'b0, 1'b0);
      t_hold();
      t_reserved();
      t_between_edges();
      t_reset_override();
      finish_run();
   end

endmodule